// File: doc/BRIEF.md
# Data-Dependent Fail-First Loop Sequencer

This block walks a vector of VL elements in program order, one element per clock. For each element it reads a 4-bit condition field produced from that element's result. It tests one chosen bit of that field against an invert flag. The first element that fails the test ends the loop at once, and the vector length is truncated. The length is never cut for any other reason. For each element the block reports the element index, a result-write enable and a condition-write enable. When the loop ends it reports the new VL and gives a one-cycle done pulse.

A 5-bit mode word and an Rc flag configure a run. Mode bits [4:3] must be 2'b01 or the start is ignored. Bit [2] is the invert flag. With Rc=1, bits [1:0] pick the tested condition bit. With Rc=0, the equal bit is always tested: bit [1] is the inclusive-length flag and bit [0] is the compare-only flag. The condition field is ordered {lt, gt, eq, so} on cr_i[3:0]. Selector value s tests cr_i[3-s], so 0 selects lt, 1 gt, 2 eq and 3 so.

Top module: `ffirst_seq`

## Requirements
- R1: A start with mode_i[4:3]==2'b01 and vl_i>0, taken while the block is idle, makes elem_valid_o high in each of the following cycles, with elem_idx_o counting 0,1,2,... in order.
- R2: An element passes when its tested condition bit differs from the invert flag mode_i[2]. It fails when the bit equals the flag.
- R3: With Rc=1, mode_i[1:0]=s selects cr_i[3-s] as the tested bit. With Rc=0, cr_i[1] (eq) is always tested.
- R4: On the first failing element no further element is issued. done_o pulses in the next cycle.
- R5: new_vl_o equals the failing index when the inclusive flag is 0. It equals that index plus one when the inclusive flag (Rc=0, mode_i[1]=1) is 1.
- R6: If no element fails, new_vl_o equals vl_i. done_o pulses one cycle after the last element.
- R7: A start with vl_i==0, or a start where element 0 fails with the inclusive flag 0, gives done_o with new_vl_o==0.
- R8: res_we_o is high for passing elements. It is high for a failing element only when the inclusive flag is 1. It is never high when compare-only (Rc=0, mode_i[0]=1) is set.
- R9: cr_we_o is high for every issued element when Rc=1 or compare-only is set, and is low otherwise.
- R10: start_i is ignored while elements are being issued, and also when mode_i[4:3]!=2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a loop |
| mode_i | input | 5 | Mode word |
| rc_i | input | 1 | Condition-record flag |
| vl_i | input | 7 | Vector length, 0..64 |
| cr_i | input | 4 | Condition field of current element {lt,gt,eq,so} |
| elem_valid_o | output | 1 | An element is issued this cycle |
| elem_idx_o | output | 7 | Index of the issued element |
| res_we_o | output | 1 | Write the element result |
| cr_we_o | output | 1 | Write the element condition field |
| new_vl_o | output | 7 | Resulting vector length, held after done |
| done_o | output | 1 | One-cycle end-of-loop pulse |

## Verification
Element 0 is issued in the cycle after the clock edge that accepts start. Each later element follows one cycle after the one before it. The write enables are combinational with the element, so they are due in the same cycle as its index. done_o and new_vl_o arrive exactly one cycle after the last issued element. A driver computes this ordered stream of element items, plus a closing length item, and queues it. A monitor samples on the falling edge and pops one item for each cycle that shows a valid element or a done pulse, so any extra, missing or late output is flagged as a mismatch.

// File: rtl/ffirst_pkg.sv
package ffirst_pkg;
  localparam int unsigned VL_W = 7;

  typedef struct packed {
    logic       inv;
    logic [1:0] sel;   // index into {lt,gt,eq,so}, 0 = lt
    logic       incl;  // failing element counts toward new length
    logic       cmp;   // compare-only: never write result
    logic       crw;   // condition field written
  } ff_cfg_t;
endpackage

// File: rtl/ffirst_decode.sv
module ffirst_decode
  import ffirst_pkg::*;
(
  input  logic [4:0] mode_i,
  input  logic       rc_i,
  output logic       sel_ok_o,
  output ff_cfg_t    cfg_o
);
  always_comb begin
    sel_ok_o   = (mode_i[4:3] == 2'b01);
    cfg_o.inv  = mode_i[2];
    cfg_o.sel  = rc_i ? mode_i[1:0] : 2'd2;
    cfg_o.incl = !rc_i && mode_i[1];
    cfg_o.cmp  = !rc_i && mode_i[0];
    cfg_o.crw  = rc_i || mode_i[0];
  end
endmodule

// File: rtl/ffirst_test.sv
module ffirst_test (
  input  logic [3:0] cr_i,
  input  logic [1:0] sel_i,
  input  logic       inv_i,
  output logic       pass_o
);
  logic bit_sel;
  always_comb begin
    bit_sel = cr_i[2'd3 - sel_i];
    pass_o  = bit_sel ^ inv_i;
  end
endmodule

// File: rtl/ffirst_ctrl.sv
module ffirst_ctrl
  import ffirst_pkg::*;
#(
  parameter int unsigned W = VL_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         sel_ok_i,
  input  logic [W-1:0] vl_i,
  input  ff_cfg_t      cfg_i,
  input  logic         pass_i,
  output ff_cfg_t      cfg_o,
  output logic         elem_valid_o,
  output logic [W-1:0] elem_idx_o,
  output logic         res_we_o,
  output logic         cr_we_o,
  output logic [W-1:0] new_vl_o,
  output logic         done_o
);
  logic         run_q, done_q;
  logic [W-1:0] idx_q, vl_q, nvl_q;
  ff_cfg_t      cfg_q;
  logic         last;

  assign last = (idx_q == vl_q - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      vl_q   <= '0;
      nvl_q  <= '0;
      cfg_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (run_q) begin
        if (!pass_i) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
          nvl_q  <= cfg_q.incl ? idx_q + W'(1) : idx_q;
        end else if (last) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
          nvl_q  <= vl_q;
        end else begin
          idx_q <= idx_q + W'(1);
        end
      end else if (start_i && sel_ok_i) begin
        cfg_q <= cfg_i;
        vl_q  <= vl_i;
        idx_q <= '0;
        if (vl_i == '0) begin
          done_q <= 1'b1;
          nvl_q  <= '0;
        end else begin
          run_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    cfg_o        = cfg_q;
    elem_valid_o = run_q;
    elem_idx_o   = idx_q;
    res_we_o     = run_q && !cfg_q.cmp && (pass_i || cfg_q.incl);
    cr_we_o      = run_q && cfg_q.crw;
    new_vl_o     = nvl_q;
    done_o       = done_q;
  end

  // R4
  stop_on_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !pass_i) |=> (!run_q && done_q));
  // R1
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && pass_i && !last) |=> (run_q && idx_q == $past(idx_q) + W'(1)));
  // R6
  len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (nvl_q <= vl_q));
  // R8
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cfg_q.cmp) |-> !res_we_o);
  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && start_i) |=> $stable(vl_q));
endmodule

// File: rtl/ffirst_seq.sv
module ffirst_seq
  import ffirst_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [4:0]      mode_i,
  input  logic            rc_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic [3:0]      cr_i,
  output logic            elem_valid_o,
  output logic [VL_W-1:0] elem_idx_o,
  output logic            res_we_o,
  output logic            cr_we_o,
  output logic [VL_W-1:0] new_vl_o,
  output logic            done_o
);
  ff_cfg_t cfg_new, cfg_act;
  logic    sel_ok, pass;

  ffirst_decode u_dec (
    .mode_i  (mode_i),
    .rc_i    (rc_i),
    .sel_ok_o(sel_ok),
    .cfg_o   (cfg_new)
  );

  ffirst_test u_test (
    .cr_i  (cr_i),
    .sel_i (cfg_act.sel),
    .inv_i (cfg_act.inv),
    .pass_o(pass)
  );

  ffirst_ctrl #(.W(VL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .sel_ok_i    (sel_ok),
    .vl_i        (vl_i),
    .cfg_i       (cfg_new),
    .pass_i      (pass),
    .cfg_o       (cfg_act),
    .elem_valid_o(elem_valid_o),
    .elem_idx_o  (elem_idx_o),
    .res_we_o    (res_we_o),
    .cr_we_o     (cr_we_o),
    .new_vl_o    (new_vl_o),
    .done_o      (done_o)
  );

  // R9
  crw_needs_elem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we_o || cr_we_o) |-> elem_valid_o);
  // R4
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !elem_valid_o);
endmodule

// File: tb/ffirst_seq_test.sv
`timescale 1ns/1ps
module ffirst_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] mode = '0;
  logic       rc = 1'b0;
  logic [6:0] vl = '0;
  logic [3:0] cr;
  logic       ev, rwe, cwe, done;
  logic [6:0] idx, nvl;

  logic [3:0] cr_tbl [64];
  int checks = 0, fails = 0;

  // kind 0 = element item, 1 = done item
  typedef struct {
    int kind; int idx; logic rwe; logic cwe; int nvl; string req;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  always_comb cr = cr_tbl[idx[5:0]];

  ffirst_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .rc_i(rc),
    .vl_i(vl), .cr_i(cr), .elem_valid_o(ev), .elem_idx_o(idx),
    .res_we_o(rwe), .cr_we_o(cwe), .new_vl_o(nvl), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_n && (ev || done)) begin
    item_t e;
    if (q.size() == 0) begin
      chk(0, "R10", $sformatf("unexpected output ev=%0b done=%0b exp=none", ev, done));
    end else begin
      e = q.pop_front();
      if (e.kind == 0)
        chk(ev && !done && idx == e.idx[6:0] && rwe == e.rwe && cwe == e.cwe, e.req,
            $sformatf("elem act ev=%0b idx=%0d rwe=%0b cwe=%0b exp idx=%0d rwe=%0b cwe=%0b",
                      ev, idx, rwe, cwe, e.idx, e.rwe, e.cwe));
      else
        chk(done && !ev && nvl == e.nvl[6:0], e.req,
            $sformatf("done act done=%0b nvl=%0d exp nvl=%0d", done, nvl, e.nvl));
    end
  end

  // driver: compute expected stream, then start
  task automatic run(input logic [4:0] m, input logic r, input int n, input string req,
                     input bit poke_busy = 0);
    bit inv = m[2];
    int sel = r ? int'(m[1:0]) : 2;
    bit incl = !r && m[1];
    bit cmp  = !r && m[0];
    bit crw  = r || m[0];
    int nv = n;
    for (int i = 0; i < n; i++) begin
      item_t e;
      bit b = cr_tbl[i][3-sel];
      bit pass = (b != inv);
      e.kind = 0; e.idx = i; e.cwe = crw; e.rwe = !cmp && (pass || incl);
      e.nvl = 0; e.req = req;
      q.push_back(e);
      if (!pass) begin nv = incl ? i + 1 : i; break; end
    end
    begin
      item_t d;
      d.kind = 1; d.idx = 0; d.rwe = 0; d.cwe = 0; d.nvl = nv; d.req = req;
      q.push_back(d);
    end
    @(negedge clk);
    mode = m; rc = r; vl = 7'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      mode = 5'b01000; rc = 1'b1; vl = 7'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fill(input logic [3:0] v);
    for (int i = 0; i < 64; i++) cr_tbl[i] = v;
  endtask

  initial begin
    fill(4'b0000);
    repeat (3) @(negedge clk);
    chk(!ev && !done && nvl == 0, "R1", $sformatf("reset ev=%0b done=%0b nvl=%0d exp 0 0 0", ev, done, nvl));
    rst_n = 1'b1;

    // R6 full length, Rc=1 eq test
    fill(4'b0010);
    run(5'b01010, 1'b1, 5, "R6");
    // R3 R5 Rc=1 gt test, fail at 2
    fill(4'b0100); cr_tbl[2] = 4'b0010;
    run(5'b01001, 1'b1, 6, "R3");
    // R5 R8 inclusive, inv=1 eq, fail at 3
    fill(4'b0000); cr_tbl[3] = 4'b0010;
    run(5'b01110, 1'b0, 8, "R5");
    // R7 element 0 fails, exclusive
    fill(4'b0000);
    run(5'b01000, 1'b0, 4, "R7");
    // R7 vl zero
    run(5'b01000, 1'b0, 0, "R7");
    // R8 R9 compare-only, fail at 4
    fill(4'b0010); cr_tbl[4] = 4'b0000;
    run(5'b01001, 1'b0, 7, "R8");
    // R9 Rc=0 no condition write
    fill(4'b0010);
    run(5'b01000, 1'b0, 3, "R9");
    // R2 lt with inv=1, fail at 1
    fill(4'b0000); cr_tbl[1] = 4'b1000;
    run(5'b01100, 1'b1, 5, "R2");
    // R3 so select, fail at 5
    fill(4'b0001); cr_tbl[5] = 4'b1110;
    run(5'b01011, 1'b1, 9, "R3");
    // R6 max length
    fill(4'b0010);
    run(5'b01010, 1'b1, 64, "R6");
    // R10 start while busy ignored
    fill(4'b0010);
    run(5'b01010, 1'b1, 6, "R10", 1);
    // R10 wrong mode ignored
    @(negedge clk);
    mode = 5'b10010; rc = 1'b1; vl = 7'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk(!ev && !done && nvl == 7'd6, "R10",
        $sformatf("bad mode ev=%0b done=%0b nvl=%0d exp 0 0 6", ev, done, nvl));
    chk(q.size() == 0, "R4", $sformatf("queue left=%0d exp 0", q.size()));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #20000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule